// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits on the receive side of an Ethernet MAC and decides, for every incoming frame, whether the frame is kept or discarded. The first six bytes of each frame, which form the destination address, arrive one per cycle on a byte strobe. The block captures them and folds them into a CRC32 as they arrive. A frame-end strobe then delivers the final frame length and an error flag. One cycle later the block issues a single decision pulse, carrying a keep/drop flag and a reason code.

Four independent checks feed the decision. The unicast check compares the address against two programmed station addresses. The multicast check looks the address up in a 128-bin hash table indexed by seven CRC bits. The runt check compares the frame length with a programmed minimum. The fragment check drops frames flagged as errored.

A small write-only register port loads the control word, the two station addresses and the four hash words. While a low-power flag is raised, writes to the address and hash tables are discarded, but the control word stays writable. Software leaves the control word at zero, which keeps every check off, until the tables are loaded.

Top module: `rx_dest_filter`

## Requirements
- R1: After reset, the control word, both station addresses and all hash words are zero, and no decision pulse is issued until a frame end is seen.
- R2: A frame end (`fe_valid` high for one cycle) gives exactly one `dec_valid` pulse in the following cycle, and `dec_valid` is never high otherwise. While `dec_valid` is low, `dec_accept` and `dec_reason` are 0.
- R3: With a control word of zero, every frame is kept with reason 0, whatever its address, length or error flag.
- R4: When control bit 2 is set, a frame whose first address byte has bit 0 clear is kept only if all six bytes equal station address A or station address B; otherwise it is dropped with reason 1. Select 1 holds the two leading octets of A in bits 15:8 and 7:0, and those of B in bits 31:24 and 23:16. Select 2 (A) and select 3 (B) hold octets 2 to 5 in bits 31:24 down to 7:0.
- R5: When control bit 1 is set, a group-addressed frame that is not broadcast is looked up by index = bits 29:23 of the CRC32 over the six address bytes. The CRC uses polynomial 0x04C11DB7, starts at all ones, takes each byte's bits least significant first and is not inverted. Hash word k (selects 4 to 7) holds bins 32k to 32k+31, with bin = index mod 32. A bin holding 0 drops the frame with reason 2.
- R6: With control bit 1 clear, every group-addressed frame passes the address check.
- R7: The all-ones broadcast address always passes the address check, whatever the hash table holds.
- R8: A frame whose length is below control bits 31:16 is dropped with reason 3.
- R9: With control bit 3 set, a frame ending with the error flag is dropped with reason 4. With bit 3 clear, the error flag has no effect.
- R10: When several checks fail, the reported reason is fragment first, then runt, then the address check.
- R11: While `lowpwr` is high, writes to selects 1 to 7 leave the tables unchanged, while a write to select 0 still updates the control word.
- R12: A kept frame reports reason 0. A dropped frame reports 1 (unicast miss), 2 (hash miss), 3 (runt) or 4 (fragment).
- R13: Address bytes beyond the sixth within a frame are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lowpwr | input | 1 | Low-power flag, blocks table writes |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select: 0 control, 1 shared high octets, 2/3 low octets of A/B, 4..7 hash words |
| cfg_wdata | input | 32 | Register write data |
| da_valid | input | 1 | Address byte strobe |
| da_byte | input | 8 | Address byte, first byte first |
| fe_valid | input | 1 | Frame-end strobe |
| fe_len | input | 16 | Final frame length in bytes |
| fe_err | input | 1 | Frame error flag |
| dec_valid | output | 1 | Decision pulse |
| dec_accept | output | 1 | 1 keep, 0 drop |
| dec_reason | output | 3 | Reason code |

## Verification
The bench probes addresses that match the high octets of one station address and the low octets of the other. A design that compared each half on its own would wrongly keep these frames. It programs exactly the hash bin of a chosen group address and then probes a neighbour bin. A wrong CRC bit order or a wrong word/bit split would swap hits and misses. Frames that fail runt and fragment together, and lengths exactly at the minimum, expose a wrong priority or an off-by-one compare. Writes during low power followed by lookups show whether a table that should be frozen was updated anyway.

// File: rtl/rxf_pkg.sv
// Shared definitions for the receive destination filter: reason codes,
// register select values, control bit positions and the CRC step.
package rxf_pkg;

    typedef enum logic [2:0] {
        RSN_PASS      = 3'd0,
        RSN_UNI_MISS  = 3'd1,
        RSN_HASH_MISS = 3'd2,
        RSN_RUNT      = 3'd3,
        RSN_FRAG      = 3'd4
    } rsn_e;

    localparam int DA_BYTES    = 6;
    localparam int DA_W        = 8 * DA_BYTES;
    localparam int SEL_CTRL    = 0;
    localparam int SEL_UHI     = 1;
    localparam int SEL_ULO_A   = 2;
    localparam int SEL_ULO_B   = 3;
    localparam int SEL_HASH0   = 4;
    localparam int BIT_HASH_EN = 1;
    localparam int BIT_UNI_EN  = 2;
    localparam int BIT_FRAG_EN = 3;
    localparam int MINLEN_LSB  = 16;
    localparam logic [31:0] CRC_POLY = 32'h04C1_1DB7;

    // Advance a MSB-first CRC32 register by one byte taken LSB first.
    function automatic logic [31:0] crc_byte(input logic [31:0] c, input logic [7:0] d);
        logic [31:0] r;
        r = c;
        for (int i = 0; i < 8; i++) begin
            if (r[31] ^ d[i]) r = {r[30:0], 1'b0} ^ CRC_POLY;
            else              r = {r[30:0], 1'b0};
        end
        return r;
    endfunction

endpackage

// File: rtl/rxf_cfg_regs.sv
// Register bank of the filter: control word, two station addresses and
// the hash words. Assumes one write per cycle; table writes (every select
// other than the control word) are dropped while lowpwr is high.
module rxf_cfg_regs
    import rxf_pkg::*;
#(
    parameter int HASH_WORDS = 4,
    parameter int SEL_W      = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     lowpwr,
    input  logic                     we,
    input  logic [SEL_W-1:0]         sel,
    input  logic [31:0]              wdata,
    output logic [31:0]              ctrl,
    output logic [DA_W-1:0]          uni_a,
    output logic [DA_W-1:0]          uni_b,
    output logic [32*HASH_WORDS-1:0] hash_bins
);

    logic [31:0] ctrl_q;
    logic [31:0] uhi_q;
    logic [31:0] ulo_a_q;
    logic [31:0] ulo_b_q;
    logic        tbl_we;

    assign tbl_we = we && !lowpwr;

    // Control word: writable in every power state.
    always_ff @(posedge clk) begin
        if (!rst_n)                             ctrl_q <= '0;
        else if (we && sel == SEL_W'(SEL_CTRL)) ctrl_q <= wdata;
    end

    // Shared high octets of both station addresses.
    always_ff @(posedge clk) begin
        if (!rst_n)                                uhi_q <= '0;
        else if (tbl_we && sel == SEL_W'(SEL_UHI)) uhi_q <= wdata;
    end

    // Low octets of station address A.
    always_ff @(posedge clk) begin
        if (!rst_n)                                  ulo_a_q <= '0;
        else if (tbl_we && sel == SEL_W'(SEL_ULO_A)) ulo_a_q <= wdata;
    end

    // Low octets of station address B.
    always_ff @(posedge clk) begin
        if (!rst_n)                                  ulo_b_q <= '0;
        else if (tbl_we && sel == SEL_W'(SEL_ULO_B)) ulo_b_q <= wdata;
    end

    generate
        for (genvar g = 0; g < HASH_WORDS; g++) begin : g_hash
            logic [31:0] word_q;
            // One hash word, bins 32*g .. 32*g+31.
            always_ff @(posedge clk) begin
                if (!rst_n)                                      word_q <= '0;
                else if (tbl_we && sel == SEL_W'(SEL_HASH0 + g)) word_q <= wdata;
            end
            assign hash_bins[32*g +: 32] = word_q;
        end
    endgenerate

    assign ctrl  = ctrl_q;
    assign uni_a = {uhi_q[15:8],  uhi_q[7:0],   ulo_a_q};
    assign uni_b = {uhi_q[31:24], uhi_q[23:16], ulo_b_q};

endmodule

// File: rtl/rxf_da_capture.sv
// Captures the destination address of the current frame and folds each
// byte into a CRC32. Assumes the address bytes arrive before the frame
// end strobe; bytes past the address length are ignored. The frame end
// clears the capture for the next frame.
module rxf_da_capture
    import rxf_pkg::*;
#(
    parameter int NBYTES = DA_BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              da_valid,
    input  logic [7:0]        da_byte,
    input  logic              fe_valid,
    output logic [8*NBYTES-1:0] da,
    output logic [31:0]       crc
);

    localparam int CNT_W = $clog2(NBYTES + 1);

    logic [CNT_W-1:0]    cnt_q;
    logic [8*NBYTES-1:0] da_q;
    logic [31:0]         crc_q;
    logic                take;

    assign take = da_valid && (cnt_q < CNT_W'(NBYTES));

    // Byte counter: counts address bytes, restarts at frame end.
    always_ff @(posedge clk) begin
        if (!rst_n || fe_valid) cnt_q <= '0;
        else if (take)          cnt_q <= cnt_q + 1'b1;
    end

    // Address shift register, first byte ends up most significant.
    always_ff @(posedge clk) begin
        if (!rst_n || fe_valid) da_q <= '0;
        else if (take)          da_q <= {da_q[8*NBYTES-9:0], da_byte};
    end

    // Running CRC over the address bytes.
    always_ff @(posedge clk) begin
        if (!rst_n || fe_valid) crc_q <= '1;
        else if (take)          crc_q <= crc_byte(crc_q, da_byte);
    end

    assign da  = da_q;
    assign crc = crc_q;

endmodule

// File: rtl/rxf_decide.sv
// Evaluates the four acceptance checks on the captured address and the
// frame-end information, and registers a one-cycle decision pulse.
// Priority: fragment, then runt, then the address check.
module rxf_decide
    import rxf_pkg::*;
#(
    parameter int HASH_BITS = 7,
    parameter int CRC_LO    = 23,
    parameter int LEN_W     = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [31:0]               ctrl,
    input  logic [DA_W-1:0]           uni_a,
    input  logic [DA_W-1:0]           uni_b,
    input  logic [(1<<HASH_BITS)-1:0] hash_bins,
    input  logic [DA_W-1:0]           da,
    input  logic [31:0]               crc,
    input  logic                      fe_valid,
    input  logic [LEN_W-1:0]          fe_len,
    input  logic                      fe_err,
    output logic                      dec_valid,
    output logic                      dec_accept,
    output logic [2:0]                dec_reason
);

    logic [HASH_BITS-1:0] idx;
    logic [LEN_W-1:0]     minlen;
    logic                 is_group;
    logic                 is_bcast;
    logic                 uni_hit;
    logic                 bin_hit;
    rsn_e                 rsn_n;

    // Evaluate the checks in priority order.
    always_comb begin
        idx      = crc[CRC_LO +: HASH_BITS];
        minlen   = ctrl[MINLEN_LSB +: LEN_W];
        is_group = da[DA_W-8];
        is_bcast = &da;
        uni_hit  = (da == uni_a) || (da == uni_b);
        bin_hit  = hash_bins[idx];
        rsn_n    = RSN_PASS;
        if (ctrl[BIT_FRAG_EN] && fe_err) begin
            rsn_n = RSN_FRAG;
        end else if (fe_len < minlen) begin
            rsn_n = RSN_RUNT;
        end else if (is_group) begin
            if (!is_bcast && ctrl[BIT_HASH_EN] && !bin_hit) rsn_n = RSN_HASH_MISS;
        end else if (ctrl[BIT_UNI_EN] && !uni_hit) begin
            rsn_n = RSN_UNI_MISS;
        end
    end

    // Decision register: one pulse per frame end, zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_valid  <= 1'b0;
            dec_accept <= 1'b0;
            dec_reason <= 3'd0;
        end else begin
            dec_valid  <= fe_valid;
            dec_accept <= fe_valid && (rsn_n == RSN_PASS);
            dec_reason <= fe_valid ? 3'(rsn_n) : 3'd0;
        end
    end

endmodule

// File: rtl/rx_dest_filter.sv
// Receive destination address filter. Captures the six destination
// address bytes of each frame, and one cycle after the frame-end strobe
// issues a keep/drop pulse with a reason code. Assumes at most one frame
// end per two cycles and no table write in the frame-end cycle.
module rx_dest_filter
    import rxf_pkg::*;
#(
    parameter int HASH_BITS = 7,
    parameter int CRC_LO    = 23,
    parameter int LEN_W     = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lowpwr,
    input  logic             cfg_we,
    input  logic [2:0]       cfg_sel,
    input  logic [31:0]      cfg_wdata,
    input  logic             da_valid,
    input  logic [7:0]       da_byte,
    input  logic             fe_valid,
    input  logic [LEN_W-1:0] fe_len,
    input  logic             fe_err,
    output logic             dec_valid,
    output logic             dec_accept,
    output logic [2:0]       dec_reason
);

    localparam int NBINS      = 1 << HASH_BITS;
    localparam int HASH_WORDS = NBINS / 32;

    logic [31:0]      ctrl;
    logic [DA_W-1:0]  uni_a;
    logic [DA_W-1:0]  uni_b;
    logic [NBINS-1:0] hash_bins;
    logic [DA_W-1:0]  da;
    logic [31:0]      crc;

    rxf_cfg_regs #(.HASH_WORDS(HASH_WORDS), .SEL_W(3)) u_regs (
        .clk(clk), .rst_n(rst_n), .lowpwr(lowpwr), .we(cfg_we),
        .sel(cfg_sel), .wdata(cfg_wdata), .ctrl(ctrl),
        .uni_a(uni_a), .uni_b(uni_b), .hash_bins(hash_bins)
    );

    rxf_da_capture #(.NBYTES(DA_BYTES)) u_cap (
        .clk(clk), .rst_n(rst_n), .da_valid(da_valid), .da_byte(da_byte),
        .fe_valid(fe_valid), .da(da), .crc(crc)
    );

    rxf_decide #(.HASH_BITS(HASH_BITS), .CRC_LO(CRC_LO), .LEN_W(LEN_W)) u_dec (
        .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .uni_a(uni_a), .uni_b(uni_b),
        .hash_bins(hash_bins), .da(da), .crc(crc), .fe_valid(fe_valid),
        .fe_len(fe_len), .fe_err(fe_err), .dec_valid(dec_valid),
        .dec_accept(dec_accept), .dec_reason(dec_reason)
    );

endmodule

// File: rtl/rxf_checker.sv
// Property checker for rx_dest_filter, attached with bind.
module rxf_checker #(
    parameter int LEN_W = 16,
    parameter int TBL_W = 224
) (
    input logic             clk,
    input logic             rst_n,
    input logic             lowpwr,
    input logic             cfg_we,
    input logic [2:0]       cfg_sel,
    input logic             fe_valid,
    input logic [LEN_W-1:0] fe_len,
    input logic             fe_err,
    input logic [31:0]      ctrl,
    input logic [TBL_W-1:0] tables,
    input logic             dec_valid,
    input logic             dec_accept,
    input logic [2:0]       dec_reason
);

    // R2
    pulse_after_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fe_valid |=> dec_valid);

    // R2
    no_spurious_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fe_valid |=> !dec_valid && !dec_accept && dec_reason == 3'd0);

    // R12
    keep_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && dec_accept) |-> dec_reason == 3'd0);

    // R12
    drop_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && !dec_accept) |-> (dec_reason >= 3'd1 && dec_reason <= 3'd4));

    // R11
    frozen_tables_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lowpwr && cfg_we && cfg_sel != 3'd0) |=> $stable(tables));

    // R3
    open_filter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fe_valid && ctrl == 32'd0) |=> dec_accept);

    // R8
    runt_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fe_valid && fe_len < ctrl[16 +: LEN_W]) |=> !dec_accept);

    // R9
    frag_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fe_valid && fe_err && ctrl[3]) |=> (dec_reason == 3'd4));

endmodule

bind rx_dest_filter rxf_checker #(.LEN_W(LEN_W), .TBL_W(2*48 + NBINS)) u_rxf_checker (
    .clk(clk), .rst_n(rst_n), .lowpwr(lowpwr), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .fe_valid(fe_valid), .fe_len(fe_len), .fe_err(fe_err), .ctrl(ctrl),
    .tables({uni_a, uni_b, hash_bins}), .dec_valid(dec_valid),
    .dec_accept(dec_accept), .dec_reason(dec_reason)
);

// File: tb/test_rx_dest_filter.sv
`timescale 1ns/1ps
module test_rx_dest_filter;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lowpwr = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic        da_valid = 1'b0;
    logic [7:0]  da_byte = '0;
    logic        fe_valid = 1'b0;
    logic [15:0] fe_len = '0;
    logic        fe_err = 1'b0;
    logic        dec_valid;
    logic        dec_accept;
    logic [2:0]  dec_reason;

    always #2.5 clk = ~clk;

    rx_dest_filter i_rx_dest_filter (
        .clk(clk), .rst_n(rst_n), .lowpwr(lowpwr), .cfg_we(cfg_we),
        .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .da_valid(da_valid),
        .da_byte(da_byte), .fe_valid(fe_valid), .fe_len(fe_len),
        .fe_err(fe_err), .dec_valid(dec_valid), .dec_accept(dec_accept),
        .dec_reason(dec_reason)
    );

    int    n_vec = 0;
    int    n_bad = 0;
    string tag = "R1";
    bit    done = 1'b0;

    // ---------------- behavioural reference model ----------------
    logic [31:0] m_reg [8];
    byte unsigned m_da [$];
    logic        e_v, e_acc;
    logic [2:0]  e_rsn;

    function automatic logic [31:0] ref_crc(input byte unsigned b [$]);
        logic [31:0] c = 32'hFFFF_FFFF;
        foreach (b[i]) for (int k = 0; k < 8; k++) begin
            logic top = c[31];
            c = c << 1;
            if (top ^ b[i][k]) c = c ^ 32'h04C1_1DB7;
        end
        return c;
    endfunction

    function automatic int bin_of(input logic [47:0] a);
        byte unsigned q [$];
        for (int i = 0; i < 6; i++) q.push_back(a[47-8*i -: 8]);
        return int'((ref_crc(q) >> 23) & 32'h7F);
    endfunction

    function automatic logic [2:0] ref_decide(input logic [15:0] len, input logic err);
        logic [31:0] c = m_reg[0];
        logic [47:0] a = '0, sa, sb;
        int idx;
        foreach (m_da[i]) a = {a[39:0], m_da[i]};
        sa = {m_reg[1][15:0], m_reg[2]};
        sb = {m_reg[1][31:16], m_reg[3]};
        idx = int'((ref_crc(m_da) >> 23) & 32'h7F);
        if (c[3] && err) return 3'd4;
        if (int'(len) < int'(c[31:16])) return 3'd3;
        if (a[40]) begin
            if (a != 48'hFFFF_FFFF_FFFF && c[1] && !m_reg[4 + idx/32][idx%32]) return 3'd2;
            return 3'd0;
        end
        if (c[2] && a != sa && a != sb) return 3'd1;
        return 3'd0;
    endfunction

    // Model update at each rising edge: decide with old tables, then write.
    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (m_reg[i]) m_reg[i] = '0;
            m_da.delete();
            e_v = 0; e_acc = 0; e_rsn = 0;
        end else begin
            e_v = fe_valid; e_acc = 0; e_rsn = 0;
            if (fe_valid) begin
                e_rsn = ref_decide(fe_len, fe_err);
                e_acc = (e_rsn == 3'd0);
                m_da.delete();
            end else if (da_valid && m_da.size() < 6) begin
                m_da.push_back(da_byte);
            end
            if (cfg_we && (cfg_sel == 3'd0 || !lowpwr)) m_reg[cfg_sel] = cfg_wdata;
        end
    end

    // Compare on every falling edge.
    always @(negedge clk) begin
        if (!done) begin
            n_vec++;
            if ({dec_valid, dec_accept, dec_reason} !== {e_v, e_acc, e_rsn}) begin
                n_bad++;
                $display("FAIL %s: valid/accept/reason actual %b/%b/%0d expected %b/%b/%0d at %0t",
                         tag, dec_valid, dec_accept, dec_reason, e_v, e_acc, e_rsn, $time);
            end
        end
    end

    // ---------------- stimulus ----------------
    task automatic wr(input int sel, input logic [31:0] d);
        cfg_we = 1; cfg_sel = 3'(sel); cfg_wdata = d;
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic frame(input logic [47:0] a, input int extra, input int len, input bit err);
        for (int i = 0; i < 6 + extra; i++) begin
            da_valid = 1;
            da_byte  = (i < 6) ? a[47-8*i -: 8] : 8'($urandom);
            @(negedge clk);
        end
        da_valid = 0;
        fe_valid = 1; fe_len = 16'(len); fe_err = err;
        @(negedge clk);
        fe_valid = 0; fe_err = 0;
        @(negedge clk);
    endtask

    // Direct output check used for the low-power observations.
    task automatic expect_reason(input logic [2:0] r, input string t);
        n_vec++;
        if (!dec_valid || dec_reason !== r) begin
            n_bad++;
            $display("FAIL %s: reason actual %0d expected %0d", t, dec_reason, r);
        end
    endtask

    localparam logic [47:0] STA = 48'h02_11_22_33_44_55;
    localparam logic [47:0] STB = 48'h06_AA_66_77_88_99;
    localparam logic [47:0] BC  = 48'hFF_FF_FF_FF_FF_FF;
    localparam logic [47:0] MC1 = 48'h01_00_5E_00_00_01;

    initial begin : wdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin : main
        logic [47:0] mc2;
        int b1;
        repeat (4) @(negedge clk);
        rst_n = 1;
        repeat (3) @(negedge clk);

        // R1: tables zero after reset; hash-only filter then misses everything
        tag = "R1";
        frame(MC1, 0, 64, 0);
        wr(0, 32'h2);
        frame(MC1, 0, 64, 0);

        // R3: open filter keeps short, errored and unknown frames
        tag = "R3";
        wr(0, 32'h0);
        frame(48'h00_12_34_56_78_9A, 0, 10, 1);
        frame(MC1, 0, 1, 0);

        // program tables
        wr(1, {STB[47:32], STA[47:32]});
        wr(2, STA[31:0]);
        wr(3, STB[31:0]);
        b1 = bin_of(MC1);
        wr(4 + b1/32, 32'(1) << (b1 % 32));
        mc2 = MC1 + 48'd1;
        while (bin_of(mc2) == b1 || bin_of(mc2)/32 == b1/32 && 0) mc2 = mc2 + 48'd1;
        wr(0, {16'd64, 16'h000E});

        // R4: exact match on either station, cross-mixed halves miss
        tag = "R4";
        frame(STA, 0, 64, 0);
        frame(STB, 0, 100, 0);
        frame({STA[47:32], STB[31:0]}, 0, 64, 0);
        frame({STB[47:32], STA[31:0]}, 0, 64, 0);
        frame(48'h00_00_00_00_00_00, 0, 64, 0);

        // R5: hash bin hit and neighbour miss
        tag = "R5";
        frame(MC1, 0, 64, 0);
        frame(mc2, 0, 64, 0);

        // R7: broadcast kept despite hash table
        tag = "R7";
        frame(BC, 0, 64, 0);

        // R8: minimum length boundary
        tag = "R8";
        frame(STA, 0, 63, 0);
        frame(STA, 0, 64, 0);

        // R9 / R10: fragment and priority
        tag = "R10";
        frame(48'h00_00_00_00_00_01, 0, 20, 1);
        frame(mc2, 0, 20, 0);
        tag = "R9";
        wr(0, {16'd64, 16'h0006});
        frame(STA, 0, 64, 1);

        // R6: group frames pass with hash off
        tag = "R6";
        wr(0, {16'd64, 16'h0004});
        frame(mc2, 0, 64, 0);

        // R13: trailing bytes after the address do not change the result
        tag = "R13";
        wr(0, {16'd64, 16'h000E});
        frame(STA, 5, 64, 0);
        frame(48'h00_11_22_33_44_56, 4, 64, 0);

        // R11: low power freezes tables but not the control word
        tag = "R11";
        lowpwr = 1;
        for (int w = 4; w < 8; w++) wr(w, 32'hFFFF_FFFF);
        wr(2, 32'h0);
        wr(0, {16'd64, 16'h000E});
        lowpwr = 0;
        da_valid = 0;
        frame(mc2, 0, 64, 0);
        frame(STA, 0, 64, 0);
        lowpwr = 1;
        wr(0, {16'd200, 16'h000E});
        lowpwr = 0;
        for (int i = 0; i < 6; i++) begin
            da_valid = 1; da_byte = STA[47-8*i -: 8]; @(negedge clk);
        end
        da_valid = 0; fe_valid = 1; fe_len = 16'd100; @(negedge clk);
        fe_valid = 0;
        expect_reason(3'd3, "R11");
        @(negedge clk);

        // R2 / R12: randomized traffic with table rewrites and low power
        tag = "R12";
        for (int n = 0; n < 300; n++) begin
            int k = $urandom_range(0, 9);
            logic [47:0] a;
            lowpwr = ($urandom_range(0, 4) == 0);
            if (k == 0) wr($urandom_range(0, 7),
                           ($urandom_range(0, 1) ? 32'($urandom) : {16'($urandom_range(0, 80)), 16'($urandom)}));
            case ($urandom_range(0, 5))
                0: a = STA;
                1: a = STB;
                2: a = BC;
                3: a = {8'h01, 40'($urandom_range(0, 31))};
                default: a = {16'($urandom), 32'($urandom)};
            endcase
            lowpwr = 0;
            frame(a, $urandom_range(0, 2), $urandom_range(0, 120), $urandom_range(0, 3) == 0);
        end

        tag = "R2";
        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule